// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block drives the timing side of a parallel LCD panel: a horizontal sync, a vertical sync and a data-enable strobe, plus a plain active-area flag and zero-based pixel coordinates for the logic that supplies pixel data. It runs on the pixel clock. A horizontal counter steps through the clocks of each line and a vertical counter steps through the lines of each frame. The lengths come from run-time inputs: for each axis, a total length, an active length, a back-porch length and a sync width. The back-porch length is counted from the first cycle of the sync pulse, so it already contains the sync cycles. Active video on an axis therefore starts at position `bporch` and ends before position `bporch + active`. Whatever remains of the total is front porch.

The timing inputs and the polarity selects are copied into shadow registers only when a frame starts, so a frame never mixes two timings. A three-state controller sequences the block:
- **ST_IDLE**: the block is disabled. Both counters are held at zero and every output sits at its inactive level.
- **ST_RUN**: a valid timing is being scanned.
- **ST_FAULT**: the captured timing is invalid. The counters still run using the captured totals, but the outputs are held inactive.

The controller has these transitions:
- `start`: ST_IDLE to ST_RUN or ST_FAULT when the enable is seen high.
- `frame_wrap`: at the last clock of a frame, from ST_RUN or ST_FAULT to ST_RUN or ST_FAULT. Which state follows depends on the values being captured.
- `stop`: any state to ST_IDLE when the enable is seen low.

A launch-edge select chooses whether the output pins are launched on the rising edge or on the following falling edge of the pixel clock.

Top module: `display_timing_gen`

## Requirements
- R1: While reset is asserted, and until the first enabled position is output, hsync_o, vsync_o, de_o, active_o, x_o and y_o are all 0, given pol_i = 0.
- R2: The line length is h_total_i clocks. hsync is true during horizontal positions 0 to h_sync_i-1 of every line.
- R3: The frame length is v_total_i lines. vsync is true during every clock of lines 0 to v_sync_i-1.
- R4: active_o is 1 exactly when the horizontal position lies in [h_bporch_i, h_bporch_i+h_active_i) and the vertical position lies in [v_bporch_i, v_bporch_i+v_active_i). The data-enable signal is true at exactly the same positions, including a timing with no front porch (back porch plus active equal to total).
- R5: While active_o is 1, x_o = horizontal position − h_bporch_i and y_o = vertical position − v_bporch_i. While active_o is 0, both coordinates are 0.
- R6: A sync width of 0 keeps that sync signal false for the whole frame.
- R7: pol_i[0], pol_i[1] and pol_i[2] invert hsync_o, vsync_o and de_o respectively (1 = low-active). active_o, x_o and y_o are never inverted.
- R8: With edge_rise_i = 1, the output for a counter position appears one rising edge after that position. With edge_rise_i = 0, it appears at the falling edge that follows, half a clock later. Position (0,0) is the first position after enable is sampled high.
- R9: Timing and polarity inputs are captured only when enabling from idle, or at the last clock of a frame. Changes made mid-frame affect nothing before the next frame.
- R10: A captured timing is invalid if either axis has active = 0, or back porch plus active greater than total. During an invalid frame, all syncs, DE and active stay inactive and the coordinates stay 0. The timing is re-evaluated at every frame boundary.
- R11: When en_i is sampled low, the counters return to (0,0) and the outputs go inactive. Enabling again restarts at position (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| h_total_i | input | 15 | Clocks per line |
| h_active_i | input | 13 | Active clocks per line |
| h_bporch_i | input | 14 | Back porch, counted from sync start |
| h_sync_i | input | 12 | Horizontal sync width |
| v_total_i | input | 15 | Lines per frame |
| v_active_i | input | 13 | Active lines per frame |
| v_bporch_i | input | 14 | Vertical back porch, counted from sync start |
| v_sync_i | input | 12 | Vertical sync width in lines |
| pol_i | input | 3 | Low-active selects: bit0 hsync, bit1 vsync, bit2 DE |
| edge_rise_i | input | 1 | 1 = rising-edge launch, 0 = falling-edge launch |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |
| active_o | output | 1 | Active-area flag, always high-true |
| x_o | output | 13 | Pixel column within the active area |
| y_o | output | 13 | Pixel row within the active area |

## Verification
The bench targets the following corner cases:
- **No front porch.** A timing with no front porch, where back porch plus active equals total. A design with an off-by-one in the window end would keep DE high into the sync of the next line.
- **Zero sync width.** A wrap-around compare would instead produce a full-line or full-frame pulse.
- **Mid-frame changes.** Timing and polarity are changed mid-frame. A design without shadowing would bend the current frame.
- **Invalid timings.** Both a back porch plus active overrun and a zero active length are used. Here a wrong design would raise DE or coordinates, or would fail to recover at the next frame boundary.
- **Disable and re-enable mid-frame.** A design that fails to restart would resume at a stale position.
- **Falling-edge launch.** Pins are sampled both before and after the falling edge. An output stage that ignores the select would show the new value half a clock early.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int TOT_W  = 15;
    localparam int ACT_W  = 13;
    localparam int BP_W   = 14;
    localparam int SYNC_W = 12;
    localparam int SUM_W  = TOT_W + 1;
    localparam int POL_W  = 3;

    typedef struct packed {
        logic [TOT_W-1:0]  total;
        logic [ACT_W-1:0]  active;
        logic [BP_W-1:0]   bporch;
        logic [SYNC_W-1:0] sync_w;
    } axis_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } run_state_e;

    // A timing is usable when its active window is non-empty and fits in the total
    function automatic logic axis_ok(axis_cfg_t c);
        logic [SUM_W-1:0] span;
        span = SUM_W'(c.bporch) + SUM_W'(c.active);
        return (c.active != '0) && (span <= SUM_W'(c.total));
    endfunction

endpackage

// File: rtl/dtg_axis_decode.sv
module dtg_axis_decode
    import dtg_pkg::*;
(
    input  axis_cfg_t          cfg_i,
    input  logic [TOT_W-1:0]   pos_i,
    output logic               sync_o,
    output logic               win_o,
    output logic               last_o,
    output logic [ACT_W-1:0]   coord_o
);

    logic [SUM_W-1:0] pos_x;
    logic [SUM_W-1:0] bp_x;
    logic [SUM_W-1:0] end_x;
    logic [SUM_W-1:0] sw_x;
    logic [SUM_W-1:0] tot_x;

    assign pos_x = SUM_W'(pos_i);
    assign bp_x  = SUM_W'(cfg_i.bporch);
    assign end_x = bp_x + SUM_W'(cfg_i.active);
    assign sw_x  = SUM_W'(cfg_i.sync_w);
    assign tot_x = SUM_W'(cfg_i.total);

    assign sync_o  = pos_x < sw_x;
    assign win_o   = (pos_x >= bp_x) && (pos_x < end_x);
    assign last_o  = (pos_x + SUM_W'(1)) >= tot_x;
    assign coord_o = win_o ? ACT_W'(pos_x - bp_x) : '0;

    always_comb begin
        if (cfg_i.sync_w == '0) begin
            // R6
            zero_sync_chk: assert (!sync_o) else $error("sync asserted with zero width");
        end
    end

endmodule

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  axis_cfg_t         live_h_i,
    input  axis_cfg_t         live_v_i,
    input  logic [POL_W-1:0]  live_pol_i,
    input  logic              h_last_i,
    input  logic              v_last_i,
    output run_state_e        state_o,
    output logic [TOT_W-1:0]  hpos_o,
    output logic [TOT_W-1:0]  vpos_o,
    output axis_cfg_t         sh_h_o,
    output axis_cfg_t         sh_v_o,
    output logic [POL_W-1:0]  sh_pol_o
);

    run_state_e        state_q;
    run_state_e        state_d;
    logic [TOT_W-1:0]  hpos_q;
    logic [TOT_W-1:0]  vpos_q;
    axis_cfg_t         sh_h_q;
    axis_cfg_t         sh_v_q;
    logic [POL_W-1:0]  sh_pol_q;
    logic              live_ok;
    logic              frame_end;
    logic              load;

    assign live_ok   = axis_ok(live_h_i) && axis_ok(live_v_i);
    assign frame_end = h_last_i && v_last_i;
    assign load      = en_i && ((state_q == ST_IDLE) || frame_end);

    // next-state logic: start, frame_wrap, stop
    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = live_ok ? ST_RUN : ST_FAULT;
                ST_RUN,
                ST_FAULT: if (frame_end) state_d = live_ok ? ST_RUN : ST_FAULT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counters and shadow copy of the timing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hpos_q   <= '0;
            vpos_q   <= '0;
            sh_h_q   <= '0;
            sh_v_q   <= '0;
            sh_pol_q <= '0;
        end else if (!en_i) begin
            hpos_q <= '0;
            vpos_q <= '0;
        end else if (load) begin
            hpos_q   <= '0;
            vpos_q   <= '0;
            sh_h_q   <= live_h_i;
            sh_v_q   <= live_v_i;
            sh_pol_q <= live_pol_i;
        end else if (h_last_i) begin
            hpos_q <= '0;
            vpos_q <= vpos_q + TOT_W'(1);
        end else begin
            hpos_q <= hpos_q + TOT_W'(1);
        end
    end

    assign state_o  = state_q;
    assign hpos_o   = hpos_q;
    assign vpos_o   = vpos_q;
    assign sh_h_o   = sh_h_q;
    assign sh_v_o   = sh_v_q;
    assign sh_pol_o = sh_pol_q;

    // R11
    idle_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (hpos_q == '0 && vpos_q == '0));

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && en_i && !frame_end)
        |=> ($stable(sh_h_q) && $stable(sh_v_q) && $stable(sh_pol_q)));

    // R2
    hpos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (hpos_q == '0 || hpos_q < sh_h_q.total));

    // R10
    fault_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && en_i && !frame_end) |=> (state_q == ST_FAULT));

endmodule

// File: rtl/dtg_outstage.sv
module dtg_outstage
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_rise_i,
    input  logic [POL_W-1:0]  pol_i,
    input  logic              hs_i,
    input  logic              vs_i,
    input  logic              de_i,
    input  logic [ACT_W-1:0]  x_i,
    input  logic [ACT_W-1:0]  y_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              active_o,
    output logic [ACT_W-1:0]  x_o,
    output logic [ACT_W-1:0]  y_o
);

    localparam int BUS_W = 4 + 2 * ACT_W;

    logic [BUS_W-1:0] rise_q;
    logic [BUS_W-1:0] fall_q;
    logic [BUS_W-1:0] pin_bus;
    logic             act_q;
    logic [ACT_W-1:0] x_q;
    logic [ACT_W-1:0] y_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= {hs_i ^ pol_i[0], vs_i ^ pol_i[1], de_i ^ pol_i[2],
                               de_i, x_i, y_i};
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= rise_q;
    end

    assign pin_bus = edge_rise_i ? rise_q : fall_q;
    assign {hsync_o, vsync_o, de_o, active_o, x_o, y_o} = pin_bus;

    assign act_q = rise_q[2*ACT_W];
    assign x_q   = rise_q[2*ACT_W-1:ACT_W];
    assign y_q   = rise_q[ACT_W-1:0];

    // R5
    coord_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_q |-> (x_q == '0 && y_q == '0));

endmodule

// File: rtl/display_timing_gen.sv
module display_timing_gen
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [14:0]       h_total_i,
    input  logic [12:0]       h_active_i,
    input  logic [13:0]       h_bporch_i,
    input  logic [11:0]       h_sync_i,
    input  logic [14:0]       v_total_i,
    input  logic [12:0]       v_active_i,
    input  logic [13:0]       v_bporch_i,
    input  logic [11:0]       v_sync_i,
    input  logic [2:0]        pol_i,
    input  logic              edge_rise_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              active_o,
    output logic [12:0]       x_o,
    output logic [12:0]       y_o
);

    axis_cfg_t         live_h;
    axis_cfg_t         live_v;
    axis_cfg_t         sh_h;
    axis_cfg_t         sh_v;
    logic [POL_W-1:0]  sh_pol;
    logic [POL_W-1:0]  pol_use;
    run_state_e        st;
    logic [TOT_W-1:0]  hpos;
    logic [TOT_W-1:0]  vpos;
    logic              h_sync, h_win, h_last;
    logic              v_sync, v_win, v_last;
    logic [ACT_W-1:0]  h_coord, v_coord;
    logic              running;
    logic              hs_raw, vs_raw, de_raw;
    logic [ACT_W-1:0]  x_raw, y_raw;

    assign live_h = '{total: h_total_i, active: h_active_i, bporch: h_bporch_i, sync_w: h_sync_i};
    assign live_v = '{total: v_total_i, active: v_active_i, bporch: v_bporch_i, sync_w: v_sync_i};

    dtg_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .live_h_i   (live_h),
        .live_v_i   (live_v),
        .live_pol_i (pol_i),
        .h_last_i   (h_last),
        .v_last_i   (v_last),
        .state_o    (st),
        .hpos_o     (hpos),
        .vpos_o     (vpos),
        .sh_h_o     (sh_h),
        .sh_v_o     (sh_v),
        .sh_pol_o   (sh_pol)
    );

    dtg_axis_decode u_hdec (
        .cfg_i   (sh_h),
        .pos_i   (hpos),
        .sync_o  (h_sync),
        .win_o   (h_win),
        .last_o  (h_last),
        .coord_o (h_coord)
    );

    dtg_axis_decode u_vdec (
        .cfg_i   (sh_v),
        .pos_i   (vpos),
        .sync_o  (v_sync),
        .win_o   (v_win),
        .last_o  (v_last),
        .coord_o (v_coord)
    );

    // output decode: only a valid running frame drives anything active
    always_comb begin
        running = (st == ST_RUN);
        hs_raw  = running && h_sync;
        vs_raw  = running && v_sync;
        de_raw  = running && h_win && v_win;
        x_raw   = de_raw ? h_coord : '0;
        y_raw   = de_raw ? v_coord : '0;
        pol_use = (st == ST_IDLE) ? pol_i : sh_pol;
    end

    dtg_outstage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_rise_i (edge_rise_i),
        .pol_i       (pol_use),
        .hs_i        (hs_raw),
        .vs_i        (vs_raw),
        .de_i        (de_raw),
        .x_i         (x_raw),
        .y_i         (y_raw),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .de_o        (de_o),
        .active_o    (active_o),
        .x_o         (x_o),
        .y_o         (y_o)
    );

    // R4
    window_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && h_win && v_win) |-> (hpos >= TOT_W'(sh_h.bporch) && vpos >= TOT_W'(sh_v.bporch)));

endmodule

// File: tb/display_timing_gen_tb.sv
module display_timing_gen_tb;

    typedef struct {
        int tot;
        int act;
        int bp;
        int sw;
    } ax_t;

    typedef struct {
        bit hs;
        bit vs;
        bit de;
        bit act;
        int x;
        int y;
    } pins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    ax_t      lh, lv;
    bit [2:0] lpol;
    bit       len;
    bit       ledge;

    logic        hsync_o, vsync_o, de_o, active_o;
    logic [12:0] x_o, y_o;

    display_timing_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (len),
        .h_total_i   (15'(lh.tot)),
        .h_active_i  (13'(lh.act)),
        .h_bporch_i  (14'(lh.bp)),
        .h_sync_i    (12'(lh.sw)),
        .v_total_i   (15'(lv.tot)),
        .v_active_i  (13'(lv.act)),
        .v_bporch_i  (14'(lv.bp)),
        .v_sync_i    (12'(lv.sw)),
        .pol_i       (lpol),
        .edge_rise_i (ledge),
        .hsync_o     (hsync_o),
        .vsync_o     (vsync_o),
        .de_o        (de_o),
        .active_o    (active_o),
        .x_o         (x_o),
        .y_o         (y_o)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;
    string tag = "R1";

    // reference position model, built from the requirements
    int       m_mode = 0;          // 0 idle, 1 run, 2 fault
    int       m_h = 0, m_v = 0;
    ax_t      m_sh, m_sv;
    bit [2:0] m_spol = 3'b000;
    pins_t    last_out;

    function automatic bit ax_ok(ax_t a);
        return (a.act != 0) && (a.bp + a.act <= a.tot);
    endfunction

    function automatic pins_t expect_of(int mode, int h, int v, ax_t sh, ax_t sv,
                                        bit [2:0] spol, bit [2:0] lp);
        pins_t    p;
        bit [2:0] pol;
        bit       hs, vs, de;
        pol = (mode == 0) ? lp : spol;
        hs = 0; vs = 0; de = 0;
        p.x = 0; p.y = 0;
        if (mode == 1) begin
            hs = h < sh.sw;
            vs = v < sv.sw;
            de = (h >= sh.bp) && (h < sh.bp + sh.act) && (v >= sv.bp) && (v < sv.bp + sv.act);
            if (de) begin
                p.x = h - sh.bp;
                p.y = v - sv.bp;
            end
        end
        p.hs  = hs ^ pol[0];
        p.vs  = vs ^ pol[1];
        p.de  = de ^ pol[2];
        p.act = de;
        return p;
    endfunction

    task automatic compare(pins_t e, string why);
        n_chk++;
        if (hsync_o !== e.hs || vsync_o !== e.vs || de_o !== e.de || active_o !== e.act ||
            x_o !== 13'(e.x) || y_o !== 13'(e.y)) begin
            n_fail++;
            $display("FAIL %s %s t=%0t: got hs=%b vs=%b de=%b act=%b x=%0d y=%0d exp hs=%b vs=%b de=%b act=%b x=%0d y=%0d",
                     tag, why, $time, hsync_o, vsync_o, de_o, active_o, x_o, y_o,
                     e.hs, e.vs, e.de, e.act, e.x, e.y);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            pins_t e;
            e = expect_of(m_mode, m_h, m_v, m_sh, m_sv, m_spol, lpol);
            if (!len) begin
                m_mode = 0; m_h = 0; m_v = 0;
            end else if (m_mode == 0 || ((m_h + 1 >= m_sh.tot) && (m_v + 1 >= m_sv.tot))) begin
                m_sh = lh; m_sv = lv; m_spol = lpol;
                m_mode = (ax_ok(lh) && ax_ok(lv)) ? 1 : 2;
                m_h = 0; m_v = 0;
            end else if (m_h + 1 >= m_sh.tot) begin
                m_h = 0; m_v++;
            end else begin
                m_h++;
            end
            @(posedge clk);
            if (ledge) begin
                #2 compare(e, "rising launch");
            end else begin
                #2 compare(last_out, "R8 before falling edge");
                #4 compare(e, "R8 after falling edge");
            end
            last_out = e;
        end
    endtask

    task automatic set_ax(output ax_t a, input int tot, input int act, input int bp, input int sw);
        a.tot = tot; a.act = act; a.bp = bp; a.sw = sw;
    endtask

    task automatic go_idle();
        len = 0;
        tick(3);
    endtask

    task automatic t_reset();
        pins_t z;
        tag = "R1";
        z = '{hs: 0, vs: 0, de: 0, act: 0, x: 0, y: 0};
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #2 compare(z, "R1 in reset");
        end
        #2 rst_n = 1'b1;
        last_out = z;
        tick(3);
    endtask

    task automatic t_basic();
        tag = "R2 R3 R4 R5";
        ledge = 1; lpol = 3'b000;
        set_ax(lh, 12, 6, 4, 2);
        set_ax(lv, 6, 3, 2, 1);
        len = 1;
        tick(150);
    endtask

    task automatic t_nofp();
        go_idle();
        tag = "R4 no front porch";
        set_ax(lh, 10, 6, 4, 3);
        set_ax(lv, 5, 3, 2, 2);
        len = 1;
        tick(110);
    endtask

    task automatic t_zero_sync();
        go_idle();
        tag = "R6";
        set_ax(lh, 9, 5, 0, 0);
        set_ax(lv, 5, 3, 1, 0);
        len = 1;
        tick(100);
    endtask

    task automatic t_pol_fall();
        go_idle();
        tag = "R7 R8";
        lpol = 3'b111;
        ledge = 0;
        tick(2);
        set_ax(lh, 12, 6, 4, 2);
        set_ax(lv, 6, 3, 2, 1);
        len = 1;
        tick(110);
        lpol = 3'b010;
        tick(80);
        go_idle();
        ledge = 1;
        lpol = 3'b000;
        tick(2);
    endtask

    task automatic t_midchange();
        tag = "R9";
        set_ax(lh, 12, 6, 4, 2);
        set_ax(lv, 6, 3, 2, 1);
        len = 1;
        tick(20);
        set_ax(lh, 14, 5, 3, 1);
        set_ax(lv, 7, 4, 2, 2);
        lpol = 3'b101;
        tick(170);
        lpol = 3'b000;
        tick(100);
    endtask

    task automatic t_invalid();
        tag = "R10";
        set_ax(lh, 12, 8, 6, 2);
        tick(200);
        set_ax(lh, 12, 6, 4, 2);
        tick(120);
        set_ax(lv, 6, 0, 2, 1);
        tick(120);
        set_ax(lv, 6, 3, 2, 1);
        tick(120);
    endtask

    task automatic t_disable();
        tag = "R11";
        tick(17);
        len = 0;
        tick(3);
        len = 1;
        tick(90);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        lh = '{tot: 0, act: 0, bp: 0, sw: 0};
        lv = '{tot: 0, act: 0, bp: 0, sw: 0};
        m_sh = lh; m_sv = lv;
        lpol = 3'b000; len = 0; ledge = 1;
        last_out = '{hs: 0, vs: 0, de: 0, act: 0, x: 0, y: 0};
        t_reset();
        t_basic();
        t_nofp();
        t_zero_sync();
        t_pol_fall();
        t_basic();
        t_midchange();
        t_invalid();
        t_disable();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule